// File: doc/BRIEF.md
# Two-Phase Matrix Keypad Scanner

This block reads a 4x4 mechanical key matrix wired straight to eight bidirectional pads. Pads 0 to 3 carry the row lines and pads 4 to 7 carry the column lines. Each pad is modelled as an output enable, an output value and a returned input value. A line that is not driven rests low through a weak pull-down. While waiting for a press, the scanner drives every column high and watches the rows. The first rising row edge starts a debounce interval that is counted in pulses of a slow timebase strobe.

When the interval ends, the scanner drives the rows high and captures all eight lines. It then drives the columns high and captures all eight lines again. The bitwise AND of the two captures isolates the closed switch. A single-key result is translated into an 8-bit character code. The code is offered with a level-valid flag until the consumer acknowledges it. During that wait the pads are released, so no new scan can start. Results with no key or with several keys are discarded, and the scanner re-arms at once.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, and whenever the scanner is waiting for a key, `pad_oe` and `pad_out` both equal 8'hF0 (columns driven high, rows as inputs). Reset also gives `key_valid`=0, `key_code`=8'h20 and `press_count`=0.
- R2: A rising edge on any row input (bits 3:0) starts a debounce of DEBOUNCE_TICKS `tick` pulses (default 320). No scan starts and no key is reported before that count is reached.
- R3: Row edges that arrive after debounce has started are ignored, so a bouncing press yields exactly one report.
- R4: Scan phase one drives 8'h0F (rows high) on both `pad_oe` and `pad_out`. Phase two then drives 8'hF0 (columns high). Each phase lasts SETTLE_CLKS clocks (default 4), and all eight inputs are captured at the end of each phase.
- R5: The scan result is the AND of the two captures. Bits 3:0 give the row and bits 7:4 give the column. The result is valid only when exactly one bit is set in each nibble.
- R6: A valid result at row r and column c gives character index 4*r+c of the string "123A456B789C*0#D".
- R7: A result with no key, or with several keys, leaves `key_valid` low, sets `key_code` to 8'h20, leaves `press_count` unchanged and returns the scanner to waiting.
- R8: A valid result raises `key_valid` with its code and increments `press_count` by one. The flag and the code stay unchanged until a one-cycle `key_ack`, and the flag drops in the cycle after that acknowledge.
- R9: While a key is held for the consumer, all pads are released (`pad_oe`=0). Further key presses have no effect on `key_valid`, `key_code` or `press_count`.
- R10: After the acknowledge, the column drive returns. Row edges in the first SETTLE_CLKS clocks of waiting are ignored, so a key still held across the acknowledge is not reported again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe that paces the debounce count |
| pad_in | input | 8 | Levels returned by the pads (rows 3:0, columns 7:4) |
| pad_oe | output | 8 | Per-pad output enable |
| pad_out | output | 8 | Per-pad driven value |
| key_code | output | 8 | Character code of the last scan (8'h20 when not a single key) |
| key_valid | output | 1 | A decoded key waits for acknowledge |
| key_ack | input | 1 | One-cycle acknowledge from the consumer |
| press_count | output | 8 | Number of valid keys reported, modulo 256 |

## Verification
A wrong sequencing state shows up on the pad drive within one clock: `pad_oe` leaves the three legal patterns, leaves out phase one, or holds it for the wrong number of cycles. A wrong debounce count moves the `key_valid` rise outside the window of about 1280 clocks set by the strobe rate. A wrong arming or hold state produces a second report for one physical press, which shows at once as an extra step of `press_count`. A fault in decoding or validation shows on `key_code` in the first cycle that `key_valid` is high, or as a report where a multi-key closure should have been dropped.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int unsigned KP_LINES = 8;
    localparam int unsigned KP_NIB   = 4;

    localparam logic [7:0] KP_NOKEY      = 8'h20;
    localparam logic [7:0] KP_DRIVE_ROWS = 8'h0F;
    localparam logic [7:0] KP_DRIVE_COLS = 8'hF0;
    localparam logic [7:0] KP_DRIVE_NONE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_PHASE1,
        ST_PHASE2,
        ST_DECIDE,
        ST_HOLD
    } kp_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] code;
    } kp_result_t;

    // Position of the set bit in a one-hot nibble
    function automatic logic [1:0] kp_index(input logic [3:0] oh);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (oh[i]) idx = 2'(i);
        end
        return idx;
    endfunction

    // Character for a key at the given row and column
    function automatic logic [7:0] kp_char(input logic [1:0] row, input logic [1:0] col);
        logic [7:0] ch;
        unique case ({row, col})
            4'h0: ch = "1";
            4'h1: ch = "2";
            4'h2: ch = "3";
            4'h3: ch = "A";
            4'h4: ch = "4";
            4'h5: ch = "5";
            4'h6: ch = "6";
            4'h7: ch = "B";
            4'h8: ch = "7";
            4'h9: ch = "8";
            4'hA: ch = "9";
            4'hB: ch = "C";
            4'hC: ch = "*";
            4'hD: ch = "0";
            4'hE: ch = "#";
            default: ch = "D";
        endcase
        return ch;
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce #(
    parameter int unsigned TICKS = 320
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/kp_decode.sv
module kp_decode
    import kp_pkg::*;
(
    input  logic [7:0] cap_rows_hi,
    input  logic [7:0] cap_cols_hi,
    output kp_result_t result
);
    logic [7:0] merged;
    logic [3:0] row_bits;
    logic [3:0] col_bits;
    logic       single;

    always_comb begin
        merged   = cap_rows_hi & cap_cols_hi;
        row_bits = merged[3:0];
        col_bits = merged[7:4];
        single   = $onehot(row_bits) && $onehot(col_bits);
        result.valid = single;
        result.code  = single ? kp_char(kp_index(row_bits), kp_index(col_bits)) : KP_NOKEY;
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int unsigned SETTLE_CLKS    = 4,
    parameter int unsigned DEBOUNCE_TICKS = 320,
    parameter int unsigned COUNT_W        = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [7:0]         pad_in,
    output logic [7:0]         pad_oe,
    output logic [7:0]         pad_out,
    output logic [7:0]         key_code,
    output logic               key_valid,
    input  logic               key_ack,
    output logic [COUNT_W-1:0] press_count
);
    localparam int unsigned SW = $clog2(SETTLE_CLKS + 1);

    kp_state_e  state, nxt;
    logic [SW-1:0] cnt;
    logic       cnt_done;
    logic [7:0] sync_in;
    logic [3:0] row_prev;
    logic       row_rise;
    logic       deb_done;
    logic [7:0] cap1, cap2;
    kp_result_t res;

    kp_sync #(.WIDTH(KP_LINES), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    kp_debounce #(.TICKS(DEBOUNCE_TICKS)) u_deb (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_DEBOUNCE),
        .tick (tick),
        .done (deb_done)
    );

    kp_decode u_dec (
        .cap_rows_hi (cap1),
        .cap_cols_hi (cap2),
        .result      (res)
    );

    assign cnt_done = (cnt == SW'(SETTLE_CLKS - 1));
    assign row_rise = |(sync_in[3:0] & ~row_prev);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (cnt_done && row_rise) nxt = ST_DEBOUNCE;
            ST_DEBOUNCE: if (deb_done) nxt = ST_PHASE1;
            ST_PHASE1:   if (cnt_done) nxt = ST_PHASE2;
            ST_PHASE2:   if (cnt_done) nxt = ST_DECIDE;
            ST_DECIDE:   nxt = res.valid ? ST_HOLD : ST_IDLE;
            ST_HOLD:     if (key_ack) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_PHASE1: pad_oe = KP_DRIVE_ROWS;
            ST_HOLD:   pad_oe = KP_DRIVE_NONE;
            default:   pad_oe = KP_DRIVE_COLS;
        endcase
        pad_out = pad_oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            row_prev    <= '0;
            cap1        <= '0;
            cap2        <= '0;
            key_code    <= KP_NOKEY;
            press_count <= '0;
        end else begin
            state    <= nxt;
            row_prev <= sync_in[3:0];
            if (nxt != state) cnt <= '0;
            else if (!cnt_done) cnt <= cnt + 1'b1;
            if (state == ST_PHASE1 && cnt_done) cap1 <= sync_in;
            if (state == ST_PHASE2 && cnt_done) cap2 <= sync_in;
            if (state == ST_DECIDE) begin
                key_code <= res.code;
                if (res.valid) press_count <= press_count + 1'b1;
            end
        end
    end

    assign key_valid = (state == ST_HOLD);
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
    parameter int unsigned COUNT_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         pad_oe,
    input logic [7:0]         pad_out,
    input logic               key_valid,
    input logic               key_ack,
    input logic [7:0]         key_code,
    input logic [COUNT_W-1:0] press_count
);
    AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (pad_out == pad_oe) && (pad_oe == 8'hF0 || pad_oe == 8'h0F || pad_oe == 8'h00)); // R4

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (pad_oe == 8'h0F) |=> (pad_oe == 8'h0F || pad_oe == 8'hF0)); // R4

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (key_valid && !key_ack) |=> key_valid); // R8

    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (key_valid && !key_ack) |=> $stable(key_code)); // R8

    AST_VALID_NOT_BLANK: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> (key_code != 8'h20)); // R7

    AST_COUNT_ON_REPORT: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> (press_count == $past(press_count) + 1'b1)); // R8

    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$rose(key_valid) |-> $stable(press_count)); // R9

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (key_valid && key_ack) |=> (!key_valid && pad_oe == 8'hF0)); // R10
endmodule

bind keypad_scanner kp_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .key_valid   (key_valid),
    .key_ack     (key_ack),
    .key_code    (key_code),
    .press_count (press_count)
);

// File: tb/keypad_scanner_tb.sv
module keypad_scanner_tb;
    localparam int SETTLE = 4;
    localparam int DEB    = 320;
    localparam int TDIV   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] pad_in;
    logic [7:0] pad_oe, pad_out;
    logic [7:0] key_code;
    logic       key_valid;
    logic       key_ack = 1'b0;
    logic [7:0] press_count;

    logic [3:0][3:0] keys = '0;   // keys[row][col]

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int p1_len = 0;
    int exp_cnt = 0;
    bit finished = 0;
    int tdiv = 0;

    always #2 clk = ~clk;

    keypad_scanner u_dut (
        .clk (clk), .rst (rst), .tick (tick), .pad_in (pad_in),
        .pad_oe (pad_oe), .pad_out (pad_out), .key_code (key_code),
        .key_valid (key_valid), .key_ack (key_ack), .press_count (press_count)
    );

    // Keypad with pull-downs: a closed switch passes a driven-high line to its partner
    always_comb begin
        logic [7:0] drv;
        drv = pad_oe & pad_out;
        pad_in = drv;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                if (keys[r][c]) begin
                    if (drv[4+c]) pad_in[r] = 1'b1;
                    if (drv[r])   pad_in[4+c] = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        tick <= (tdiv == 0);
        cyc++;
        if (pad_oe == 8'h0F) p1_len++;
        if (cyc > 190000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] exp_char(input int r, input int c);
        string s;
        s = "123A456B789C*0#D";
        return s[r*4+c];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full press: timing, phase length, code, hold behaviour, acknowledge
    task automatic press_key(input int r, input int c, input bit bounce);
        int lat;
        lat = 0;
        p1_len = 0;
        if (bounce) begin
            for (int b = 0; b < 6; b++) begin
                @(negedge clk); keys[r][c] = ~keys[r][c]; lat++;
                idle(4); lat += 4;
            end
        end
        @(negedge clk); keys[r][c] = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); lat++;
            if (key_valid) break;
        end
        exp_cnt = (exp_cnt + 1) % 256;
        chk(key_valid, "R8 valid", key_valid, 1);
        chk(key_code == exp_char(r, c), "R6 code", key_code, exp_char(r, c));
        chk(press_count == exp_cnt[7:0], bounce ? "R3 count" : "R8 count", press_count, exp_cnt);
        if (!bounce) chk(lat >= DEB*TDIV - 10 && lat <= DEB*TDIV + 30, "R2 latency", lat, DEB*TDIV);
        chk(p1_len == SETTLE, "R4 phase1 length", p1_len, SETTLE);
        // another key while holding
        keys[(r+1)%4][(c+2)%4] = 1'b1;
        idle(60);
        chk(key_valid && key_code == exp_char(r, c), "R9 hold code", key_code, exp_char(r, c));
        chk(pad_oe == 8'h00, "R9 pads released", pad_oe, 0);
        chk(press_count == exp_cnt[7:0], "R9 count", press_count, exp_cnt);
        key_ack = 1'b1;
        @(negedge clk); key_ack = 1'b0;
        chk(!key_valid && pad_oe == 8'hF0, "R10 ack", {key_valid, pad_oe}, 9'h0F0);
        idle(400);
        chk(!key_valid && press_count == exp_cnt[7:0], "R10 no repeat", press_count, exp_cnt);
        keys = '0;
        idle(20);
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(5);
        @(negedge clk); rst = 1'b0;
        idle(3);
        chk(pad_oe == 8'hF0 && pad_out == 8'hF0, "R1 idle drive", {pad_oe, pad_out}, 16'hF0F0);
        chk(!key_valid && key_code == 8'h20 && press_count == 0, "R1 reset outputs", {key_valid, key_code, press_count}, 17'h02000);

        // acknowledge while idle has no effect
        key_ack = 1'b1; @(negedge clk); key_ack = 1'b0; idle(3);
        chk(pad_oe == 8'hF0 && !key_valid && press_count == 0, "R9 stray ack", pad_oe, 8'hF0);

        // every key once
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                press_key(r, c, 1'b0);

        // bouncing press gives one report
        press_key(2, 1, 1'b1);

        // two keys in the same row: dropped
        @(negedge clk); keys[1][0] = 1'b1; keys[1][3] = 1'b1;
        idle(DEB*TDIV + 100);
        chk(!key_valid && key_code == 8'h20, "R5 multi row", key_code, 8'h20);
        chk(press_count == exp_cnt[7:0] && pad_oe == 8'hF0, "R7 multi rearm", press_count, exp_cnt);
        keys = '0; idle(20);

        // diagonal pair: dropped
        @(negedge clk); keys[0][0] = 1'b1; keys[3][3] = 1'b1;
        idle(DEB*TDIV + 100);
        chk(!key_valid && key_code == 8'h20, "R5 multi diag", key_code, 8'h20);
        keys = '0; idle(20);

        // press released before the debounce ends: no key found
        press_key(0, 2, 1'b0);
        @(negedge clk); keys[2][2] = 1'b1;
        idle(40); keys = '0;
        idle(DEB*TDIV + 100);
        chk(!key_valid && key_code == 8'h20, "R7 no key", key_code, 8'h20);
        chk(press_count == exp_cnt[7:0] && pad_oe == 8'hF0, "R7 count kept", press_count, exp_cnt);

        // random keys
        for (int n = 0; n < 10; n++) begin
            int rr, cc;
            rr = int'($urandom_range(3, 0));
            cc = int'($urandom_range(3, 0));
            press_key(rr, cc, ($urandom_range(3, 0) == 0));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule